// File: doc/BRIEF.md
# Multicycle 32-bit processor core with trap handling

This block is a small 32-bit processor that executes a nine-instruction integer subset (register add, subtract, and, or, signed set-less-than; word load and store; branch on equal; absolute jump). Each instruction takes several clock cycles. A single memory port carries both instruction fetches and data accesses. A single ALU does the arithmetic, the PC increment, the branch-target sum and the trap-return address. Holding registers for the instruction, the memory data, the two operands and the ALU result carry values from one step to the next. A Moore control state machine sequences the steps.

The core traps on two conditions: an opcode outside the subset, and a signed overflow on a register add or subtract. On a trap it saves the faulting instruction's address and a cause code, then resumes fetching at a fixed handler address. The saved address and cause are driven on output ports so the surrounding system can read them. Memory is expected to answer reads combinationally: `mem_rdata` reflects `mem_addr` in the same cycle, and a write takes effect at the clock edge that ends the cycle in which `mem_wr` is high.

Top module: `mc_cpu`

## Requirements
- R1: While `rst_n` is low the core holds PC at 0 in the fetch step: `mem_addr`=0, `mem_rd`=1, `mem_wr`=0, `epc_o`=0, `cause_o`=0. The first instruction is fetched from address 0.
- R2: A fetch reads the word at PC with `mem_rd` high, latches it as the current instruction, and advances PC by 4. Non-branching instructions therefore run in address order.
- R3: Cycles per instruction, counted from its fetch to the next fetch: branch and jump take 3, register ALU and store take 4, load takes 5, and an undefined opcode takes 3 up to the handler fetch. An overflowing add or subtract takes 4 up to the handler fetch.
- R4: Opcode 0 is a register operation with the fields op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Funct 0x20 adds, 0x22 subtracts, 0x24 ANDs, 0x25 ORs, and 0x2A writes 1 if rs is less than rt as signed numbers (0 otherwise). The result goes to rd.
- R5: Opcode 0x23 loads rt from memory at rs + sign-extended imm[15:0]. Opcode 0x2B writes rt to that address, with `mem_wr` high for exactly one cycle.
- R6: Opcode 0x04 compares rs with rt. If they are equal, the next PC is (address + 4) + (sign-extended imm << 2). Otherwise execution falls through.
- R7: Opcode 0x02 jumps to {upper 4 bits of address + 4, imm[25:0], 2'b00}.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: Any opcode other than 0x00, 0x02, 0x04, 0x23 or 0x2B sets `epc_o` to that instruction's address and `cause_o` to 0, and the next fetch is at 0x8000_0180.
- R10: A signed overflow on funct 0x20 or 0x22 leaves rd unchanged, sets `epc_o` to the instruction's address and `cause_o` to 1, and the next fetch is at 0x8000_0180.
- R11: `mem_rd` and `mem_wr` are never high together. `mem_wr` is high only in the data-write step of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for fetch, load or store |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, combinational from `mem_addr` |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe |
| epc_o | output | 32 | Address of the last trapping instruction |
| cause_o | output | 1 | Last trap cause: 0 undefined opcode, 1 overflow |

## Verification
Random operand pairs across all five register functions are loaded from memory, combined, and stored back. Operands are biased toward the signed extremes so that overflow and non-overflow add and subtract cases both occur, and signed ordering is exercised by slt on negative values. Directed programs separate a taken branch from a not-taken one by which stores appear and by the cycle count. A jump is shown to skip stores. A store and a load through a base register with a negative offset check the address arithmetic. A write to register 0 must still read back as zero. Every program ends in a trap whose handler stores register 3. That store reveals whether an overflowing instruction wrote its destination, and the cycle at which the handler is first fetched measures the per-instruction step counts.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [3:0] {
      ST_FETCH    = 4'd0,
      ST_DECODE   = 4'd1,
      ST_MEMADDR  = 4'd2,
      ST_MEMREAD  = 4'd3,
      ST_MEMWB    = 4'd4,
      ST_MEMWRITE = 4'd5,
      ST_EXEC     = 4'd6,
      ST_RWB      = 4'd7,
      ST_BRANCH   = 4'd8,
      ST_JUMP     = 4'd9,
      ST_TRAP_UND = 4'd10,
      ST_TRAP_OVF = 4'd11
   } mc_state_e;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } mc_aluop_e;

   typedef enum logic [0:0] {SRCA_PC = 1'b0, SRCA_REG = 1'b1} mc_srca_e;
   typedef enum logic [1:0] {SRCB_REG = 2'd0, SRCB_FOUR = 2'd1,
                             SRCB_IMM = 2'd2, SRCB_IMM4 = 2'd3} mc_srcb_e;
   typedef enum logic [1:0] {PCS_ALU = 2'd0, PCS_ALUOUT = 2'd1,
                             PCS_JUMP = 2'd2, PCS_TRAP = 2'd3} mc_pcsrc_e;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_JUMP  = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef struct packed {
      logic      pc_wr;
      logic      pc_wr_eq;
      mc_pcsrc_e pc_src;
      logic      data_addr;
      logic      mem_rd;
      logic      mem_wr;
      logic      ir_wr;
      mc_srca_e  alu_a;
      mc_srcb_e  alu_b;
      mc_aluop_e alu_op;
      logic      rf_wr;
      logic      rf_to_rd;
      logic      rf_from_mem;
      logic      trap_wr;
      logic      trap_code;
   } mc_ctl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  mc_aluop_e       op,
   output logic [XLEN-1:0] y,
   output logic            zero,
   output logic            ovf
);
   localparam int MSB = XLEN - 1;

   logic            minus;
   logic [XLEN-1:0] b_eff;
   logic [XLEN-1:0] sum;
   logic            ovf_raw;

   assign minus   = (op == ALU_SUB) || (op == ALU_SLT);
   assign b_eff   = minus ? ~b : b;
   assign sum     = a + b_eff + {{(XLEN-1){1'b0}}, minus};
   assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

   always_comb begin
      unique case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, sum[MSB] ^ ovf_raw};
         default: y = sum;
      endcase
   end

   assign zero = (y == '0);
   assign ovf  = ovf_raw && ((op == ALU_ADD) || (op == ALU_SUB));
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int XLEN    = 32,
   parameter int REG_CNT = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(REG_CNT)-1:0] ra1,
   input  logic [$clog2(REG_CNT)-1:0] ra2,
   output logic [XLEN-1:0]            rd1,
   output logic [XLEN-1:0]            rd2,
   input  logic                       we,
   input  logic [$clog2(REG_CNT)-1:0] wa,
   input  logic [XLEN-1:0]            wd
);
   localparam int AW = $clog2(REG_CNT);

   logic [XLEN-1:0] regs [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      if (i == 0) begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            regs[i] <= '0;
         end
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       regs[i] <= '0;
            else if (we && (wa == AW'(i)))    regs[i] <= wd;
         end
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic      alu_ovf,
   output mc_state_e state,
   output mc_ctl_t   ctl
);
   mc_state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      unique case (state)
         ST_FETCH:   nxt = ST_DECODE;
         ST_DECODE: begin
            unique case (opcode)
               OP_LOAD, OP_STORE: nxt = ST_MEMADDR;
               OP_RTYPE:          nxt = ST_EXEC;
               OP_BEQ:            nxt = ST_BRANCH;
               OP_JUMP:           nxt = ST_JUMP;
               default:           nxt = ST_TRAP_UND;
            endcase
         end
         ST_MEMADDR: nxt = (opcode == OP_LOAD) ? ST_MEMREAD : ST_MEMWRITE;
         ST_MEMREAD: nxt = ST_MEMWB;
         ST_EXEC:    nxt = alu_ovf ? ST_TRAP_OVF : ST_RWB;
         default:    nxt = ST_FETCH;
      endcase
   end

   function automatic mc_aluop_e fn_op(input logic [5:0] f);
      unique case (f)
         FN_SUB:  return ALU_SUB;
         FN_AND:  return ALU_AND;
         FN_OR:   return ALU_OR;
         FN_SLT:  return ALU_SLT;
         default: return ALU_ADD;
      endcase
   endfunction

   always_comb begin
      ctl        = '0;
      ctl.alu_a  = SRCA_PC;
      ctl.alu_b  = SRCB_FOUR;
      ctl.alu_op = ALU_ADD;
      ctl.pc_src = PCS_ALU;
      unique case (state)
         ST_FETCH: begin
            ctl.mem_rd = 1'b1;
            ctl.ir_wr  = 1'b1;
            ctl.pc_wr  = 1'b1;
         end
         ST_DECODE:  ctl.alu_b = SRCB_IMM4;
         ST_MEMADDR: begin
            ctl.alu_a = SRCA_REG;
            ctl.alu_b = SRCB_IMM;
         end
         ST_MEMREAD: begin
            ctl.data_addr = 1'b1;
            ctl.mem_rd    = 1'b1;
         end
         ST_MEMWB: ctl.rf_wr = 1'b1;
         ST_MEMWRITE: begin
            ctl.data_addr = 1'b1;
            ctl.mem_wr    = 1'b1;
         end
         ST_EXEC: begin
            ctl.alu_a  = SRCA_REG;
            ctl.alu_b  = SRCB_REG;
            ctl.alu_op = fn_op(funct);
         end
         ST_RWB: begin
            ctl.rf_wr    = 1'b1;
            ctl.rf_to_rd = 1'b1;
         end
         ST_BRANCH: begin
            ctl.alu_a    = SRCA_REG;
            ctl.alu_b    = SRCB_REG;
            ctl.alu_op   = ALU_SUB;
            ctl.pc_wr_eq = 1'b1;
            ctl.pc_src   = PCS_ALUOUT;
         end
         ST_JUMP: begin
            ctl.pc_wr  = 1'b1;
            ctl.pc_src = PCS_JUMP;
         end
         ST_TRAP_UND, ST_TRAP_OVF: begin
            ctl.alu_op    = ALU_SUB;
            ctl.trap_wr   = 1'b1;
            ctl.trap_code = (state == ST_TRAP_OVF);
            ctl.pc_wr     = 1'b1;
            ctl.pc_src    = PCS_TRAP;
         end
         default: ;
      endcase
      if (state == ST_MEMWB) ctl.rf_from_mem = 1'b1;
   end
endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
   import mc_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          REG_CNT      = 32,
   parameter logic [31:0] RESET_PC     = 32'h0000_0000,
   parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [XLEN-1:0] epc_o,
   output logic            cause_o
);
   localparam int AW    = $clog2(REG_CNT);
   localparam int IMM_W = 16;

   if (XLEN != 32 || REG_CNT != 32) begin : g_cfg_check
      initial assert (0) else $error("mc_cpu: instruction fields need XLEN=32 and REG_CNT=32");
   end

   mc_state_e       state;
   mc_ctl_t         ctl;
   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q, epc_q;
   logic            cause_q;
   logic [XLEN-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_y, sext, pc_nxt;
   logic            alu_zero, alu_ovf, pc_en;
   logic [AW-1:0]   rf_wa;
   logic [XLEN-1:0] rf_wd;
   logic            rf_we;

   mc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .opcode(ir_q[31:26]), .funct(ir_q[5:0]), .alu_ovf(alu_ovf),
      .state(state), .ctl(ctl)
   );

   assign rf_we = ctl.rf_wr;
   assign rf_wa = ctl.rf_to_rd ? ir_q[15:11] : ir_q[20:16];
   assign rf_wd = ctl.rf_from_mem ? mdr_q : aluout_q;

   mc_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra1(ir_q[25:21]), .ra2(ir_q[20:16]), .rd1(rf_rd1), .rd2(rf_rd2),
      .we(rf_we), .wa(rf_wa), .wd(rf_wd)
   );

   assign sext  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign alu_a = (ctl.alu_a == SRCA_REG) ? a_q : pc_q;

   always_comb begin
      unique case (ctl.alu_b)
         SRCB_REG:  alu_b = b_q;
         SRCB_FOUR: alu_b = XLEN'(4);
         SRCB_IMM:  alu_b = sext;
         default:   alu_b = sext << 2;
      endcase
   end

   mc_alu #(.XLEN(XLEN)) u_alu (
      .a(alu_a), .b(alu_b), .op(ctl.alu_op),
      .y(alu_y), .zero(alu_zero), .ovf(alu_ovf)
   );

   always_comb begin
      unique case (ctl.pc_src)
         PCS_ALU:    pc_nxt = alu_y;
         PCS_ALUOUT: pc_nxt = aluout_q;
         PCS_JUMP:   pc_nxt = {pc_q[31:28], ir_q[25:0], 2'b00};
         default:    pc_nxt = HANDLER_ADDR;
      endcase
   end

   assign pc_en = ctl.pc_wr || (ctl.pc_wr_eq && alu_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= RESET_PC;
         ir_q     <= '0;
         mdr_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
         epc_q    <= '0;
         cause_q  <= 1'b0;
      end else begin
         if (pc_en)     pc_q <= pc_nxt;
         if (ctl.ir_wr) ir_q <= mem_rdata;
         mdr_q    <= mem_rdata;
         a_q      <= rf_rd1;
         b_q      <= rf_rd2;
         aluout_q <= alu_y;
         if (ctl.trap_wr) begin
            epc_q   <= alu_y;
            cause_q <= ctl.trap_code;
         end
      end
   end

   assign mem_addr  = ctl.data_addr ? aluout_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign epc_o     = epc_q;
   assign cause_o   = cause_q;
endmodule

// File: rtl/mc_cpu_chk.sv
module mc_cpu_chk #(
   parameter int          XLEN    = 32,
   parameter logic [31:0] HANDLER = 32'h8000_0180
) (
   input logic            clk,
   input logic            rst_n,
   input logic [3:0]      state,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] ir,
   input logic [XLEN-1:0] epc,
   input logic            cause,
   input logic [XLEN-1:0] mem_rdata,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic            rf_we
);
   import mc_pkg::*;

   a_r2_fetch_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |=> (pc == $past(pc) + 32'd4) && (ir == $past(mem_rdata))
                               && (state == ST_DECODE));

   a_r3_no_short_path: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE) |=> (state != ST_FETCH) && (state != ST_DECODE));

   a_r9_undef_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRAP_UND) |=> (pc == HANDLER) && !cause
                                 && (epc == $past(pc) - 32'd4) && (state == ST_FETCH));

   a_r10_ovf_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRAP_OVF) |=> (pc == HANDLER) && cause
                                 && (epc == $past(pc) - 32'd4));

   a_r10_no_wb_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRAP_OVF) |-> !rf_we);

   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r11_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr && (state == ST_FETCH) && $stable(pc));
endmodule

bind mc_cpu mc_cpu_chk #(.XLEN(XLEN), .HANDLER(HANDLER_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .pc(pc_q), .ir(ir_q),
   .epc(epc_q), .cause(cause_q), .mem_rdata(mem_rdata),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_we(rf_we)
);

// File: tb/tb_mc_cpu.sv
`timescale 1ns/1ps
module tb_mc_cpu;
   localparam logic [31:0] HANDLER = 32'h8000_0180;
   localparam logic [31:0] UNDEF   = 32'hFC00_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, epc_o;
   logic        mem_rd, mem_wr, cause_o;

   logic [31:0] mem [256];
   assign mem_rdata = mem[mem_addr[9:2]];

   mc_cpu dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .epc_o(epc_o), .cause_o(cause_o)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int total_cyc = 0;
   int hcyc;
   int log_n;
   logic [31:0] log_a [8];
   logic [31:0] log_d [8];
   logic [31:0] exp_a [8];
   logic [31:0] exp_d [8];

   always @(posedge clk) begin
      total_cyc++;
      if (total_cyc > 150000) begin
         failures++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", total_cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction
   function automatic logic [31:0] enc_j(input int tgt);
      return {6'h02, 26'(tgt)};
   endfunction

   function automatic logic [31:0] ref_alu(input logic [5:0] f, input logic [31:0] a, b,
                                           output bit ov);
      logic [31:0] r;
      ov = 1'b0;
      case (f)
         6'h20: begin r = a + b; ov = (a[31] == b[31]) && (r[31] != a[31]); end
         6'h22: begin r = a - b; ov = (a[31] != b[31]) && (r[31] != a[31]); end
         6'h24: r = a & b;
         6'h25: r = a | b;
         default: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
      return r;
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      mem[96] = enc_i(6'h2B, 0, 3, 524);
      mem[97] = enc_i(6'h2B, 0, 0, 1020);
   endtask

   task automatic run();
      int  cyc;
      bit  done, clash;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 reset mem_addr", mem_addr, 32'h0);
      chk("R1 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd2);
      chk("R1 reset epc", epc_o, 32'h0);
      chk("R1 reset cause", {31'd0, cause_o}, 32'h0);
      rst_n = 1'b1;
      cyc = 0; done = 0; clash = 0; hcyc = -1; log_n = 0;
      while (!done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
         if (mem_rd && mem_wr) clash = 1;
         if (mem_rd && mem_addr == HANDLER && hcyc < 0) hcyc = cyc;
         if (mem_wr) begin
            if (mem_addr == 32'd1020) done = 1;
            else begin
               if (log_n < 8) begin
                  log_a[log_n] = mem_addr;
                  log_d[log_n] = mem_wdata;
               end
               log_n++;
               mem[mem_addr[9:2]] = mem_wdata;
            end
         end
      end
      chk("R11 strobes exclusive", {31'd0, clash}, 32'd0);
      chk("run completes", {31'd0, done}, 32'd1);
   endtask

   task automatic verify(input string req, input string trq, input int n_exp, input int cyc_exp,
                         input logic [31:0] epc_exp, input logic cause_exp);
      chk({req, " store count"}, 32'(log_n), 32'(n_exp));
      for (int i = 0; i < n_exp && i < log_n && i < 8; i++) begin
         chk({req, " store addr"}, log_a[i], exp_a[i]);
         chk({req, " store data"}, log_d[i], exp_d[i]);
      end
      chk({req, " R2 R3 cycles to handler"}, 32'(hcyc), 32'(cyc_exp));
      chk({trq, " epc"}, epc_o, epc_exp);
      chk({trq, " cause"}, {31'd0, cause_o}, {31'd0, cause_exp});
   endtask

   task automatic alu_case(input logic [5:0] f, input logic [31:0] a, b);
      bit          ov;
      logic [31:0] r;
      clear_mem();
      mem[0] = enc_i(6'h23, 0, 1, 512);
      mem[1] = enc_i(6'h23, 0, 2, 516);
      mem[2] = enc_r(1, 2, 3, f);
      mem[3] = enc_i(6'h2B, 0, 3, 520);
      mem[4] = UNDEF;
      mem[128] = a;
      mem[129] = b;
      r = ref_alu(f, a, b, ov);
      run();
      if (ov) begin
         exp_a[0] = 524; exp_d[0] = 32'h0;
         verify("R10 overflow no write", "R10", 1, 14, 32'd8, 1'b1);
      end else begin
         exp_a[0] = 520; exp_d[0] = r;
         exp_a[1] = 524; exp_d[1] = r;
         verify("R4 R5 alu result", "R9", 2, 21, 32'd16, 1'b0);
      end
   endtask

   initial begin
      logic [5:0] fns [5];
      void'($urandom(32'd20240917));
      fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;

      // R10: directed overflow on add and on sub
      alu_case(6'h20, 32'h7FFF_FFFF, 32'h1);
      alu_case(6'h22, 32'h8000_0000, 32'h1);
      // R4: signed compare with a negative operand, and a non-overflowing extreme add
      alu_case(6'h2A, 32'hFFFF_FFFF, 32'h1);
      alu_case(6'h2A, 32'h1, 32'hFFFF_FFFF);
      alu_case(6'h20, 32'h7FFF_FFFF, 32'hFFFF_FFFF);

      // R4 R10: random operands, biased toward signed extremes
      for (int k = 0; k < 40; k++) begin
         logic [31:0] a, b;
         a = $urandom;
         b = $urandom;
         if (k % 3 == 0) a = {2'b01, a[29:0]};
         if (k % 3 == 1) a = {2'b10, a[29:0]};
         alu_case(fns[$urandom % 5], a, b);
      end

      // R8: writing register 0 leaves it reading zero
      clear_mem();
      mem[0] = enc_i(6'h23, 0, 1, 512);
      mem[1] = enc_i(6'h23, 0, 2, 516);
      mem[2] = enc_r(1, 2, 0, 6'h20);
      mem[3] = enc_i(6'h2B, 0, 0, 520);
      mem[4] = UNDEF;
      mem[128] = 32'h1234; mem[129] = 32'h10;
      run();
      exp_a[0] = 520; exp_d[0] = 0;
      exp_a[1] = 524; exp_d[1] = 0;
      verify("R8 zero register", "R9", 2, 21, 32'd16, 1'b0);

      // R6: branch taken skips the store
      clear_mem();
      mem[0] = enc_i(6'h23, 0, 1, 512);
      mem[1] = enc_i(6'h23, 0, 2, 516);
      mem[2] = enc_i(6'h04, 1, 2, 1);
      mem[3] = enc_i(6'h2B, 0, 1, 520);
      mem[4] = UNDEF;
      mem[128] = 32'hABCD; mem[129] = 32'hABCD;
      run();
      exp_a[0] = 524; exp_d[0] = 0;
      verify("R6 branch taken", "R9", 1, 16, 32'd16, 1'b0);

      // R6: branch not taken falls through to the store
      mem[128] = 32'hABCD; mem[129] = 32'hABCE;
      mem[130] = 0; mem[131] = 0;
      run();
      exp_a[0] = 520; exp_d[0] = 32'hABCD;
      exp_a[1] = 524; exp_d[1] = 0;
      verify("R6 branch not taken", "R9", 2, 20, 32'd16, 1'b0);

      // R7: jump skips two stores
      clear_mem();
      mem[0] = enc_j(3);
      mem[1] = enc_i(6'h2B, 0, 0, 520);
      mem[2] = enc_i(6'h2B, 0, 0, 520);
      mem[3] = UNDEF;
      run();
      exp_a[0] = 524; exp_d[0] = 0;
      verify("R7 jump", "R9", 1, 6, 32'd12, 1'b0);

      // R5: base register plus negative offset for store and load
      clear_mem();
      mem[0] = enc_i(6'h23, 0, 1, 512);
      mem[1] = enc_i(6'h2B, 1, 1, -80);
      mem[2] = enc_i(6'h23, 1, 3, -84);
      mem[3] = UNDEF;
      mem[128] = 32'd600; mem[129] = 32'h5A5A_0F0F;
      run();
      exp_a[0] = 520; exp_d[0] = 32'd600;
      exp_a[1] = 524; exp_d[1] = 32'h5A5A_0F0F;
      verify("R5 offset addressing", "R9", 2, 17, 32'd12, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule